// File: doc/BRIEF.md
# RISC Instruction Decoder and Control

This block turns one 32-bit instruction word into everything a single-cycle datapath needs to carry it out. It pulls the three register indices and the 16-bit literal out of the word, widens the literal with its sign, and forms the word-scaled displacement used by branch targets and PC-relative loads. From the 6-bit opcode it derives the ALU function, the choice of second operand, the register write enable, the write-back source, the memory strobes, the branch kind and a flag for opcodes outside the table.

It is purely combinational: the word goes in and the controls come out in the same cycle, with no clock and no state. Register and literal forms of an operation share one ALU function code. The forms differ only in the operand-B select. A store turns the second register read port to the Rc field so the data to be written can be fetched. Branches and jumps select the link value (PC+4) for write-back into Rc.

Top module: `insn_decoder`

## Requirements
- R1: For every word, rc_idx = bits [25:21], ra_idx = bits [20:16], rb_idx = bits [15:11]; imm is bits [15:0] sign-extended to 32 bits and disp is imm shifted left by two; bits [10:0] never change any control output.
- R2: Register-form opcodes decode to reg_we=1, wb_sel=0 (ALU), opb_imm=0 and alu_fn as follows: 0x20 add=0, 0x21 sub=1, 0x22 mul=2, 0x23 div=3, 0x28 and=4, 0x29 or=5, 0x2A xor=6, 0x2C shift-left=7, 0x2D logical shift-right=8, 0x2E arithmetic shift-right=9.
- R3: Each register-form opcode plus 0x10 (0x30-0x33, 0x38-0x3A, 0x3C-0x3E) is its literal form: the same alu_fn, reg_we=1, wb_sel=0, with opb_imm=1.
- R4: Opcode 0x18 (load, address Ra+literal) gives alu_fn=0, opb_imm=1, mem_rd=1, reg_we=1, wb_sel=1 (memory), addr_pcrel=0.
- R5: Opcode 0x1F (PC-relative load, address PC+4+disp) gives mem_rd=1, reg_we=1, wb_sel=1, addr_pcrel=1, alu_fn=0, opb_imm=0; no other opcode sets addr_pcrel.
- R6: Opcode 0x19 (store) gives alu_fn=0, opb_imm=1, mem_wr=1, reg_we=0, wb_sel=0, and rd2_idx equals the Rc field; for every other word rd2_idx equals the Rb field.
- R7: Opcode 0x1B (jump to the address in Ra) gives br_kind=1, reg_we=1, wb_sel=2 (link), alu_fn=0, opb_imm=0.
- R8: Opcode 0x1C (branch if Ra is zero) gives br_kind=2 and opcode 0x1D (branch if Ra is non-zero) gives br_kind=3, both with reg_we=1, wb_sel=2, alu_fn=0, opb_imm=0; the taken target is PC+4+disp.
- R9: Every opcode not listed in R2-R8 sets illegal=1 with all other control outputs 0; listed opcodes set illegal=0.
- R10: mem_rd is 1 only for 0x18 and 0x1F and mem_wr only for 0x19; wb_sel=2 occurs exactly when br_kind is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rc_idx_o | output | 5 | Destination / store-data register field |
| ra_idx_o | output | 5 | First source register field |
| rb_idx_o | output | 5 | Second source register field |
| rd2_idx_o | output | 5 | Address for the second read port |
| imm_o | output | 32 | Sign-extended literal |
| disp_o | output | 32 | Literal times four, for PC-relative targets |
| alu_fn_o | output | 4 | ALU function code |
| opb_imm_o | output | 1 | 1: operand B is the literal, 0: register |
| reg_we_o | output | 1 | Register write enable |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| br_kind_o | output | 2 | 0 none, 1 jump via Ra, 2 if Ra zero, 3 if Ra non-zero |
| addr_pcrel_o | output | 1 | Memory address taken from PC+4+disp |
| illegal_o | output | 1 | Opcode outside the table |

## Verification
Two functions meet in a single word. A branch or jump requests a control transfer and also a link write into Rc. A store redirects the second read port to Rc while it suppresses the register write. The opcode table walk shows these together for every listed code. Directed words with distinct Rc and Rb fields show that the port redirection happens on a store and on nothing else. The bench judges each word by comparing the whole control bundle against the expected bundle, so a dropped link write or a leaked write enable shows up at once. Literals at the sign boundary, the all-ones padding and the gaps in the opcode table cover the remaining corners.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int OPC_W      = 6;
  localparam int NUM_ALU_FN = 10;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0, FN_SUB = 4'd1, FN_MUL = 4'd2, FN_DIV = 4'd3,
    FN_AND = 4'd4, FN_OR  = 4'd5, FN_XOR = 4'd6,
    FN_SHL = 4'd7, FN_SHR = 4'd8, FN_SRA = 4'd9
  } alu_fn_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_LINK = 2'd2
  } wb_sel_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_REG  = 2'd1,
    BR_EQZ  = 2'd2,
    BR_NEZ  = 2'd3
  } br_kind_e;

  typedef enum logic [3:0] {
    CL_ALU_R, CL_ALU_I, CL_LD, CL_LDR, CL_ST,
    CL_JMP, CL_BEQ, CL_BNE, CL_BAD
  } op_class_e;

  localparam logic [OPC_W-1:0] OP_LD   = 6'h18;
  localparam logic [OPC_W-1:0] OP_ST   = 6'h19;
  localparam logic [OPC_W-1:0] OP_JMP  = 6'h1B;
  localparam logic [OPC_W-1:0] OP_BEQ  = 6'h1C;
  localparam logic [OPC_W-1:0] OP_BNE  = 6'h1D;
  localparam logic [OPC_W-1:0] OP_LDR  = 6'h1F;
  localparam logic [OPC_W-1:0] IMM_OFS = 6'h10;

  // Register-form opcode of ALU function k; literal form adds IMM_OFS.
  function automatic logic [OPC_W-1:0] alu_base(input int k);
    logic [OPC_W-1:0] code;
    if (k < 4)      code = OPC_W'(32'h20 + k);
    else if (k < 7) code = OPC_W'(32'h28 + k - 4);
    else            code = OPC_W'(32'h2C + k - 7);
    return code;
  endfunction

  typedef struct packed {
    alu_fn_e  alu_fn;
    logic     opb_imm;
    logic     reg_we;
    wb_sel_e  wb_sel;
    logic     mem_rd;
    logic     mem_wr;
    br_kind_e br_kind;
    logic     addr_pcrel;
    logic     illegal;
    logic     rd2_is_rc;
  } ctrl_t;

endpackage

// File: rtl/insn_dec_fields.sv
module insn_dec_fields
  import insn_dec_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5,
  parameter int LIT_W  = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [OPC_W-1:0]  opc_o,
  output logic [RIDX_W-1:0] rc_o,
  output logic [RIDX_W-1:0] ra_o,
  output logic [RIDX_W-1:0] rb_o,
  output logic [XLEN-1:0]   imm_o,
  output logic [XLEN-1:0]   disp_o
);

  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int RC_LSB  = OPC_LSB - RIDX_W;
  localparam int RA_LSB  = RC_LSB - RIDX_W;
  localparam int RB_LSB  = RA_LSB - RIDX_W;

  logic [LIT_W-1:0] lit;

  assign opc_o = word_i[WORD_W-1:OPC_LSB];
  assign rc_o  = word_i[RC_LSB +: RIDX_W];
  assign ra_o  = word_i[RA_LSB +: RIDX_W];
  assign rb_o  = word_i[RB_LSB +: RIDX_W];
  assign lit   = word_i[LIT_W-1:0];

  if (XLEN > LIT_W) begin : g_sext
    assign imm_o = {{(XLEN-LIT_W){lit[LIT_W-1]}}, lit};
  end else begin : g_trunc
    assign imm_o = lit[XLEN-1:0];
  end

  assign disp_o = {imm_o[XLEN-3:0], 2'b00};

endmodule

// File: rtl/insn_dec_opclass.sv
module insn_dec_opclass
  import insn_dec_pkg::*;
#(
  parameter int NFN = NUM_ALU_FN
) (
  input  logic [OPC_W-1:0] opc_i,
  output op_class_e        cls_o,
  output alu_fn_e          fn_o
);

  logic [NFN-1:0] hit_reg;
  logic [NFN-1:0] hit_imm;
  logic [NFN-1:0] hit_any;

  for (genvar k = 0; k < NFN; k++) begin : g_fn
    assign hit_reg[k] = (opc_i == alu_base(k));
    assign hit_imm[k] = (opc_i == (alu_base(k) | IMM_OFS));
  end

  assign hit_any = hit_reg | hit_imm;

  always_comb begin
    fn_o = FN_ADD;
    for (int k = 0; k < NFN; k++) begin
      if (hit_any[k]) fn_o = alu_fn_e'(4'(k));
    end
  end

  always_comb begin
    if (|hit_reg)      cls_o = CL_ALU_R;
    else if (|hit_imm) cls_o = CL_ALU_I;
    else begin
      case (opc_i)
        OP_LD:   cls_o = CL_LD;
        OP_LDR:  cls_o = CL_LDR;
        OP_ST:   cls_o = CL_ST;
        OP_JMP:  cls_o = CL_JMP;
        OP_BEQ:  cls_o = CL_BEQ;
        OP_BNE:  cls_o = CL_BNE;
        default: cls_o = CL_BAD;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown(opc_i)) begin
      p_fn_onehot_r2: assert ($onehot0(hit_any) && !(|hit_reg && |hit_imm))
        else $error("opcode matched more than one ALU entry");
    end
  end

endmodule

// File: rtl/insn_dec_ctrl.sv
module insn_dec_ctrl
  import insn_dec_pkg::*;
(
  input  op_class_e cls_i,
  input  alu_fn_e   fn_i,
  output ctrl_t     ctrl_o
);

  always_comb begin
    ctrl_o = '{alu_fn: FN_ADD, opb_imm: 1'b0, reg_we: 1'b0, wb_sel: WB_ALU,
               mem_rd: 1'b0, mem_wr: 1'b0, br_kind: BR_NONE,
               addr_pcrel: 1'b0, illegal: 1'b0, rd2_is_rc: 1'b0};
    case (cls_i)
      CL_ALU_R: begin
        ctrl_o.alu_fn = fn_i;
        ctrl_o.reg_we = 1'b1;
      end
      CL_ALU_I: begin
        ctrl_o.alu_fn  = fn_i;
        ctrl_o.opb_imm = 1'b1;
        ctrl_o.reg_we  = 1'b1;
      end
      CL_LD: begin
        ctrl_o.opb_imm = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.wb_sel  = WB_MEM;
        ctrl_o.mem_rd  = 1'b1;
      end
      CL_LDR: begin
        ctrl_o.reg_we     = 1'b1;
        ctrl_o.wb_sel     = WB_MEM;
        ctrl_o.mem_rd     = 1'b1;
        ctrl_o.addr_pcrel = 1'b1;
      end
      CL_ST: begin
        ctrl_o.opb_imm   = 1'b1;
        ctrl_o.mem_wr    = 1'b1;
        ctrl_o.rd2_is_rc = 1'b1;
      end
      CL_JMP: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.wb_sel  = WB_LINK;
        ctrl_o.br_kind = BR_REG;
      end
      CL_BEQ: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.wb_sel  = WB_LINK;
        ctrl_o.br_kind = BR_EQZ;
      end
      CL_BNE: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.wb_sel  = WB_LINK;
        ctrl_o.br_kind = BR_NEZ;
      end
      default: ctrl_o.illegal = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown(cls_i)) begin
      p_mem_excl_r10: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
        else $error("read and write strobes together");
      p_bad_quiet_r9: assert (!ctrl_o.illegal ||
                              (!ctrl_o.reg_we && !ctrl_o.mem_rd && !ctrl_o.mem_wr &&
                               ctrl_o.br_kind == BR_NONE))
        else $error("illegal opcode left a side effect enabled");
    end
  end

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5,
  parameter int LIT_W  = 16
) (
  input  logic [WORD_W-1:0] instr_i,
  output logic [RIDX_W-1:0] rc_idx_o,
  output logic [RIDX_W-1:0] ra_idx_o,
  output logic [RIDX_W-1:0] rb_idx_o,
  output logic [RIDX_W-1:0] rd2_idx_o,
  output logic [XLEN-1:0]   imm_o,
  output logic [XLEN-1:0]   disp_o,
  output logic [3:0]        alu_fn_o,
  output logic              opb_imm_o,
  output logic              reg_we_o,
  output logic [1:0]        wb_sel_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [1:0]        br_kind_o,
  output logic              addr_pcrel_o,
  output logic              illegal_o
);

  logic [OPC_W-1:0] opc;
  op_class_e        cls;
  alu_fn_e          fn;
  ctrl_t            ctrl;

  insn_dec_fields #(
    .WORD_W (WORD_W),
    .XLEN   (XLEN),
    .RIDX_W (RIDX_W),
    .LIT_W  (LIT_W)
  ) u_fields (
    .word_i (instr_i),
    .opc_o  (opc),
    .rc_o   (rc_idx_o),
    .ra_o   (ra_idx_o),
    .rb_o   (rb_idx_o),
    .imm_o  (imm_o),
    .disp_o (disp_o)
  );

  insn_dec_opclass #(.NFN(NUM_ALU_FN)) u_opclass (
    .opc_i (opc),
    .cls_o (cls),
    .fn_o  (fn)
  );

  insn_dec_ctrl u_ctrl (
    .cls_i  (cls),
    .fn_i   (fn),
    .ctrl_o (ctrl)
  );

  assign rd2_idx_o    = ctrl.rd2_is_rc ? rc_idx_o : rb_idx_o;
  assign alu_fn_o     = ctrl.alu_fn;
  assign opb_imm_o    = ctrl.opb_imm;
  assign reg_we_o     = ctrl.reg_we;
  assign wb_sel_o     = ctrl.wb_sel;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign br_kind_o    = ctrl.br_kind;
  assign addr_pcrel_o = ctrl.addr_pcrel;
  assign illegal_o    = ctrl.illegal;

  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_link_pair_r8: assert ((wb_sel_o == WB_LINK) == (br_kind_o != BR_NONE))
        else $error("link write-back and branch kind disagree");
      p_store_nowb_r6: assert (!mem_wr_o || (!reg_we_o && rd2_idx_o == rc_idx_o))
        else $error("store writes a register or reads the wrong port");
      p_pcrel_load_r5: assert (!addr_pcrel_o || (mem_rd_o && !opb_imm_o))
        else $error("PC-relative address without a plain load");
      p_immform_r3: assert (!(instr_i[WORD_W-1 -: 2] == 2'b11 && !illegal_o) || opb_imm_o)
        else $error("literal-form ALU opcode did not select the literal");
    end
  end

endmodule

// File: tb/tb_insn_decoder.sv
module tb_insn_decoder;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [4:0]  rc_idx, ra_idx, rb_idx, rd2_idx;
  logic [31:0] imm, disp;
  logic [3:0]  alu_fn;
  logic        opb_imm, reg_we, mem_rd, mem_wr, addr_pcrel, illegal;
  logic [1:0]  wb_sel, br_kind;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  insn_decoder dut (
    .instr_i      (instr),
    .rc_idx_o     (rc_idx),
    .ra_idx_o     (ra_idx),
    .rb_idx_o     (rb_idx),
    .rd2_idx_o    (rd2_idx),
    .imm_o        (imm),
    .disp_o       (disp),
    .alu_fn_o     (alu_fn),
    .opb_imm_o    (opb_imm),
    .reg_we_o     (reg_we),
    .wb_sel_o     (wb_sel),
    .mem_rd_o     (mem_rd),
    .mem_wr_o     (mem_wr),
    .br_kind_o    (br_kind),
    .addr_pcrel_o (addr_pcrel),
    .illegal_o    (illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // entry: {opcode, alu_fn, opb_imm, reg_we, wb_sel, mem_rd, mem_wr, br_kind, illegal, addr_pcrel}
  function automatic logic [19:0] mk(input logic [5:0] op, input logic [3:0] fn,
                                     input logic ob, input logic we, input logic [1:0] wb,
                                     input logic rd, input logic wr, input logic [1:0] br,
                                     input logic il, input logic pc);
    return {op, fn, ob, we, wb, rd, wr, br, il, pc};
  endfunction

  localparam int NV = 34;
  localparam logic [19:0] VEC [NV] = '{
    mk(6'h20, 4'd0, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h21, 4'd1, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h22, 4'd2, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h23, 4'd3, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h28, 4'd4, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h29, 4'd5, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h2A, 4'd6, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h2C, 4'd7, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h2D, 4'd8, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h2E, 4'd9, 0, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h30, 4'd0, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h31, 4'd1, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h32, 4'd2, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h33, 4'd3, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h38, 4'd4, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h39, 4'd5, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h3A, 4'd6, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h3C, 4'd7, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h3D, 4'd8, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h3E, 4'd9, 1, 1, 2'd0, 0, 0, 2'd0, 0, 0),
    mk(6'h18, 4'd0, 1, 1, 2'd1, 1, 0, 2'd0, 0, 0),
    mk(6'h19, 4'd0, 1, 0, 2'd0, 0, 1, 2'd0, 0, 0),
    mk(6'h1B, 4'd0, 0, 1, 2'd2, 0, 0, 2'd1, 0, 0),
    mk(6'h1C, 4'd0, 0, 1, 2'd2, 0, 0, 2'd2, 0, 0),
    mk(6'h1D, 4'd0, 0, 1, 2'd2, 0, 0, 2'd3, 0, 0),
    mk(6'h1F, 4'd0, 0, 1, 2'd1, 1, 0, 2'd0, 0, 1),
    mk(6'h00, 4'd0, 0, 0, 2'd0, 0, 0, 2'd0, 1, 0),
    mk(6'h24, 4'd0, 0, 0, 2'd0, 0, 0, 2'd0, 1, 0),
    mk(6'h2B, 4'd0, 0, 0, 2'd0, 0, 0, 2'd0, 1, 0),
    mk(6'h2F, 4'd0, 0, 0, 2'd0, 0, 0, 2'd0, 1, 0),
    mk(6'h34, 4'd0, 0, 0, 2'd0, 0, 0, 2'd0, 1, 0),
    mk(6'h3F, 4'd0, 0, 0, 2'd0, 0, 0, 2'd0, 1, 0),
    mk(6'h1A, 4'd0, 0, 0, 2'd0, 0, 0, 2'd0, 1, 0),
    mk(6'h1E, 4'd0, 0, 0, 2'd0, 0, 0, 2'd0, 1, 0)
  };

  function automatic string req_of(input logic [5:0] op);
    if (op inside {[6'h20:6'h23], [6'h28:6'h2A], [6'h2C:6'h2E]}) return "R2";
    if (op inside {[6'h30:6'h33], [6'h38:6'h3A], [6'h3C:6'h3E]}) return "R3";
    case (op)
      6'h18:   return "R4/R10";
      6'h1F:   return "R5/R10";
      6'h19:   return "R6/R10";
      6'h1B:   return "R7/R10";
      6'h1C,
      6'h1D:   return "R8/R10";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [13:0] ctrl_now();
    return {alu_fn, opb_imm, reg_we, wb_sel, mem_rd, mem_wr, br_kind, illegal, addr_pcrel};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    #1 instr = w;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    instr = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle word: opcode 0 is outside the table
    @(negedge clk);
    chk("R9", "zero word controls", 32'(ctrl_now()), 32'(VEC[26][13:0]));

    // table walk: rc=3, ra=9, literal 0x8A5C (rb field = 17)
    for (int i = 0; i < NV; i++) begin
      logic [5:0] op;
      op = VEC[i][19:14];
      apply({op, 5'd3, 5'd9, 16'h8A5C});
      chk(req_of(op), $sformatf("controls op %h", op), 32'(ctrl_now()), 32'(VEC[i][13:0]));
      chk(op == 6'h19 ? "R6" : "R1", $sformatf("rd2 index op %h", op),
          32'(rd2_idx), op == 6'h19 ? 32'd3 : 32'd17);
    end

    // field extraction with all-ones padding; controls as plain add
    apply({6'h20, 5'd31, 5'd0, 5'd21, 11'h7FF});
    chk("R1", "rc field", 32'(rc_idx), 32'd31);
    chk("R1", "ra field", 32'(ra_idx), 32'd0);
    chk("R1", "rb field", 32'(rb_idx), 32'd21);
    chk("R1", "padding ignored", 32'(ctrl_now()), 32'(VEC[0][13:0]));

    // largest positive literal
    apply({6'h30, 5'd1, 5'd2, 16'h7FFF});
    chk("R1", "imm +max", imm, 32'h0000_7FFF);
    chk("R1", "disp +max", disp, 32'h0001_FFFC);

    // most negative literal on a branch
    apply({6'h1C, 5'd28, 5'd4, 16'h8000});
    chk("R1", "imm -min", imm, 32'hFFFF_8000);
    chk("R8", "disp -min", disp, 32'hFFFE_0000);
    chk("R8", "branch kind eqz", 32'(br_kind), 32'd2);

    // literal -1 on a PC-relative load
    apply({6'h1F, 5'd5, 5'd6, 16'hFFFF});
    chk("R1", "imm -1", imm, 32'hFFFF_FFFF);
    chk("R5", "disp -1", disp, 32'hFFFF_FFFC);

    // store reads Rc on the second port; a shift with the same fields reads Rb
    apply({6'h19, 5'd12, 5'd1, 5'd20, 11'h000});
    chk("R6", "store rd2 is rc", 32'(rd2_idx), 32'd12);
    chk("R6", "store no write", 32'(reg_we), 32'd0);
    apply({6'h2C, 5'd12, 5'd1, 5'd20, 11'h000});
    chk("R6", "shift rd2 is rb", 32'(rd2_idx), 32'd20);

    // gap opcode with every other bit set: no side effects
    apply(32'hFFFF_FFFF);
    chk("R9", "all-ones illegal", 32'(illegal), 32'd1);
    chk("R9", "all-ones quiet", 32'({reg_we, mem_rd, mem_wr, br_kind, wb_sel}), 32'd0);

    // jump through Ra writes the link
    apply({6'h1B, 5'd28, 5'd7, 16'h0000});
    chk("R7", "jump kind", 32'(br_kind), 32'd1);
    chk("R10", "jump link select", 32'(wb_sel), 32'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule